// File: doc/BRIEF.md
# Instruction fetch trace show-cycle controller

This block sits between the instruction fetch unit of a processor core and the external bus interface. For every fetch it accepts, it decides whether the fetch carries the program-trace attribute and whether the fetch must also appear on the external bus as a show cycle. A fetch from an external device always goes out as a normal bus cycle. A fetch served by internal memory goes out only when it is a trace fetch that has to be made visible. In that case it goes out as an address-only cycle.

Visibility of trace fetches is controlled by a resynchronisation level, which the development-port logic drives as a register output, and by a control field that forces all trace fetches to be shown. Each change of the resynchronisation level, whether rising or falling, arms a one-shot flag. The flag makes the next accepted fetch a visible trace fetch, so an external trace tool can line up with the core's flow.

Fetches enter on a valid/ready handshake. The resulting bus request waits in a single holding register until the bus side grants it.

Top module: `ftrace_show_ctrl`

## Requirements
- R1: A fetch flagged as an indirect flow change carries the trace attribute, and it is signalled on `bus_trace_o` whenever that fetch is shown.
- R2: While `resync_lvl_i` is 1, every trace fetch produces a bus request, including fetches served by internal memory.
- R3: A shown fetch from an external device has `bus_addr_only_o`=0 (full cycle). A shown fetch from internal memory has `bus_addr_only_o`=1 (address-only cycle). `bus_addr_o` equals the fetch address.
- R4: A rising or falling change of `resync_lvl_i`, measured against its value in the previous cycle (0 after reset), arms a flag. The first fetch accepted in a later cycle is then a trace fetch and is shown.
- R5: The flag is cleared by the first fetch accepted after it is armed. Several level changes before that fetch tag only that one fetch.
- R6: When `show_all_i` is 1, every trace fetch is shown, whatever the level of `resync_lvl_i`.
- R7: A fetch from internal memory that is not a trace fetch produces no request. A fetch from an external device that is not a trace fetch produces a full cycle with `bus_trace_o`=0.
- R8: `fetch_ready_o` equals NOT `bus_req_o` OR `bus_gnt_i`. While `bus_req_o`=1 and `bus_gnt_i`=0, the request, its address, its cycle type and its trace flag hold in the next cycle.
- R9: After reset, `bus_req_o`=0, `fetch_ready_o`=1 and no fetch is tagged.
- R10: A trace fetch from internal memory with `resync_lvl_i`=0, `show_all_i`=0 and no armed flag produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_valid_i | input | 1 | Fetch request valid |
| fetch_ready_o | output | 1 | Fetch may be accepted |
| fetch_addr_i | input | AW | Fetch address |
| fetch_indirect_i | input | 1 | Fetch results from an indirect flow change |
| fetch_internal_i | input | 1 | Instruction is served by internal memory |
| resync_lvl_i | input | 1 | Resynchronisation level from development-port logic |
| show_all_i | input | 1 | Control field forcing all trace fetches to be shown |
| bus_req_o | output | 1 | External bus request pending |
| bus_gnt_i | input | 1 | Bus side accepts the pending request |
| bus_addr_o | output | AW | Request address |
| bus_addr_only_o | output | 1 | 1 = address-only cycle, 0 = full cycle |
| bus_trace_o | output | 1 | Request carries the trace attribute |

## Verification
A fetch accepted at a rising edge shows up on the bus outputs right after that same edge. A level change seen at one edge affects only fetches accepted at later edges. `fetch_ready_o` follows `bus_gnt_i` within the same cycle. The bench drives inputs at the falling edge and keeps a cycle model that commits at the rising edge. It compares every output at the next falling edge, so each result is sampled exactly one edge after the stimulus that caused it.

// File: rtl/ftrace_pkg.sv
package ftrace_pkg;
  typedef enum logic {
    CYC_FULL      = 1'b0,
    CYC_ADDR_ONLY = 1'b1
  } cyc_kind_e;
endpackage

// File: rtl/ftrace_resync_det.sv
module ftrace_resync_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic accept_i,
  output logic pend_o
);
  logic lvl_q, pend_q;
  logic chg;

  assign chg = lvl_i ^ lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_i;
      // a change in the accepting cycle re-arms for the next fetch
      pend_q <= chg | (pend_q & ~accept_i);
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/ftrace_classify.sv
module ftrace_classify
  import ftrace_pkg::*;
(
  input  logic      indirect_i,
  input  logic      internal_i,
  input  logic      lvl_i,
  input  logic      show_all_i,
  input  logic      pend_i,
  output logic      trace_o,
  output logic      show_o,
  output cyc_kind_e kind_o
);
  logic force_vis;

  always_comb begin
    trace_o   = indirect_i | pend_i;
    force_vis = lvl_i | show_all_i | pend_i;
    show_o    = ~internal_i | (trace_o & force_vis);
    kind_o    = internal_i ? CYC_ADDR_ONLY : CYC_FULL;
  end
endmodule

// File: rtl/ftrace_req_hold.sv
module ftrace_req_hold
  import ftrace_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  cyc_kind_e     kind_i,
  input  logic          trace_i,
  input  logic          gnt_i,
  output logic          free_o,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output cyc_kind_e     kind_o,
  output logic          trace_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      addr_o  <= '0;
      kind_o  <= CYC_FULL;
      trace_o <= 1'b0;
    end else if (load_i) begin
      req_q   <= 1'b1;
      addr_o  <= addr_i;
      kind_o  <= kind_i;
      trace_o <= trace_i;
    end else if (gnt_i) begin
      req_q   <= 1'b0;
    end
  end

  assign req_o  = req_q;
  assign free_o = ~req_q | gnt_i;
endmodule

// File: rtl/ftrace_show_ctrl.sv
module ftrace_show_ctrl
  import ftrace_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fetch_valid_i,
  output logic          fetch_ready_o,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          fetch_indirect_i,
  input  logic          fetch_internal_i,
  input  logic          resync_lvl_i,
  input  logic          show_all_i,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_addr_only_o,
  output logic          bus_trace_o
);
  logic      accept, pend, trace, show, free;
  cyc_kind_e kind, kind_q;

  assign accept        = fetch_valid_i & free;
  assign fetch_ready_o = free;

  ftrace_resync_det u_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_i    (resync_lvl_i),
    .accept_i (accept),
    .pend_o   (pend)
  );

  ftrace_classify u_cls (
    .indirect_i (fetch_indirect_i),
    .internal_i (fetch_internal_i),
    .lvl_i      (resync_lvl_i),
    .show_all_i (show_all_i),
    .pend_i     (pend),
    .trace_o    (trace),
    .show_o     (show),
    .kind_o     (kind)
  );

  ftrace_req_hold #(.AW(AW)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept & show),
    .addr_i  (fetch_addr_i),
    .kind_i  (kind),
    .trace_i (trace),
    .gnt_i   (bus_gnt_i),
    .free_o  (free),
    .req_o   (bus_req_o),
    .addr_o  (bus_addr_o),
    .kind_o  (kind_q),
    .trace_o (bus_trace_o)
  );

  assign bus_addr_only_o = (kind_q == CYC_ADDR_ONLY);
endmodule

// File: rtl/ftrace_show_ctrl_chk.sv
module ftrace_show_ctrl_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fetch_valid_i,
  input logic          fetch_ready_o,
  input logic [AW-1:0] fetch_addr_i,
  input logic          fetch_indirect_i,
  input logic          fetch_internal_i,
  input logic          resync_lvl_i,
  input logic          show_all_i,
  input logic          pend,
  input logic          bus_req_o,
  input logic          bus_gnt_i,
  input logic [AW-1:0] bus_addr_o,
  input logic          bus_addr_only_o,
  input logic          bus_trace_o
);
  logic acc;
  assign acc = fetch_valid_i & fetch_ready_o;

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i |=> bus_req_o && $stable(bus_addr_o)
      && $stable(bus_addr_only_o) && $stable(bus_trace_o));

  p_ext_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !fetch_internal_i |=> bus_req_o && !bus_addr_only_o
      && bus_addr_o == $past(fetch_addr_i));

  p_lvl_show_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && fetch_indirect_i && resync_lvl_i |=> bus_req_o && bus_trace_o
      && bus_addr_only_o == $past(fetch_internal_i));

  p_tagged_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && pend |=> bus_req_o && bus_trace_o);

  p_show_all_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && fetch_indirect_i && show_all_i |=> bus_req_o && bus_trace_o);

  p_hidden_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && fetch_internal_i && !fetch_indirect_i && !pend |=> !bus_req_o);

  p_hidden_trace_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && fetch_internal_i && !pend && !resync_lvl_i && !show_all_i |=> !bus_req_o);
endmodule

bind ftrace_show_ctrl ftrace_show_ctrl_chk #(.AW(AW)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .fetch_valid_i    (fetch_valid_i),
  .fetch_ready_o    (fetch_ready_o),
  .fetch_addr_i     (fetch_addr_i),
  .fetch_indirect_i (fetch_indirect_i),
  .fetch_internal_i (fetch_internal_i),
  .resync_lvl_i     (resync_lvl_i),
  .show_all_i       (show_all_i),
  .pend             (pend),
  .bus_req_o        (bus_req_o),
  .bus_gnt_i        (bus_gnt_i),
  .bus_addr_o       (bus_addr_o),
  .bus_addr_only_o  (bus_addr_only_o),
  .bus_trace_o      (bus_trace_o)
);

// File: tb/ftrace_show_ctrl_tb.sv
module ftrace_show_ctrl_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          f_valid = 1'b0, f_ind = 1'b0, f_int = 1'b0, lvl = 1'b0, sall = 1'b0, gnt = 1'b0;
  logic [AW-1:0] f_addr = '0;
  logic          f_ready, b_req, b_ao, b_tr;
  logic [AW-1:0] b_addr;

  int total = 0, bad = 0;

  // reference model state
  logic          m_prev = 1'b0, m_pend = 1'b0, m_req = 1'b0, m_ao = 1'b0, m_tr = 1'b0;
  logic [AW-1:0] m_addr = '0;

  always #5 clk = ~clk;

  ftrace_show_ctrl #(.AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_valid_i(f_valid), .fetch_ready_o(f_ready), .fetch_addr_i(f_addr),
    .fetch_indirect_i(f_ind), .fetch_internal_i(f_int),
    .resync_lvl_i(lvl), .show_all_i(sall),
    .bus_req_o(b_req), .bus_gnt_i(gnt), .bus_addr_o(b_addr),
    .bus_addr_only_o(b_ao), .bus_trace_o(b_tr)
  );

  function automatic logic exp_ready();
    return !m_req || gnt;
  endfunction

  task automatic chk(string tag, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "bus_req", AW'(b_req), AW'(m_req));
    if (m_req) begin
      chk(tag, "bus_addr", b_addr, m_addr);
      chk(tag, "addr_only", AW'(b_ao), AW'(m_ao));
      chk(tag, "trace", AW'(b_tr), AW'(m_tr));
    end
  endtask

  // drive at negedge, check ready, advance model at posedge, check outputs after
  task automatic cyc(string tag, logic v, logic [AW-1:0] a, logic ind, logic intl,
                     logic l, logic sa, logic g);
    logic acc, trace, show, chg;
    f_valid = v; f_addr = a; f_ind = ind; f_int = intl; lvl = l; sall = sa; gnt = g;
    #1;
    chk("R8", "ready", AW'(f_ready), AW'(exp_ready()));
    acc   = v && exp_ready();
    chg   = l != m_prev;
    trace = ind || m_pend;
    show  = !intl || (trace && (l || sa || m_pend));
    @(posedge clk);
    if (acc && show) begin
      m_req = 1'b1; m_addr = a; m_ao = intl; m_tr = trace;
    end else if (m_req && g) m_req = 1'b0;
    m_pend = chg || (m_pend && !acc);
    m_prev = l;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    #12 @(negedge clk);
    #1;
    chk("R9", "reset bus_req", AW'(b_req), 0);
    chk("R9", "reset ready", AW'(f_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: plain internal hidden, plain external full untraced
    cyc("R7", 1, 32'h100, 0, 1, 0, 0, 1);
    cyc("R7", 1, 32'h104, 0, 0, 0, 0, 0);
    // R8: hold while not granted
    cyc("R8", 1, 32'h108, 1, 0, 0, 0, 0);
    cyc("R8", 0, 32'h0, 0, 0, 0, 0, 0);
    cyc("R8", 0, 32'h0, 0, 0, 0, 0, 1);
    // R10: indirect internal hidden
    cyc("R10", 1, 32'h200, 1, 1, 0, 0, 1);
    // R1 with external indirect
    cyc("R1", 1, 32'h204, 1, 0, 0, 0, 1);
    // R4: rising change, idle, then plain internal fetch is tagged
    cyc("R4", 0, 32'h0, 0, 0, 1, 0, 1);
    cyc("R4", 1, 32'h300, 0, 1, 1, 0, 1);
    // R2: level high, internal indirect shown address-only (R3)
    cyc("R2", 1, 32'h304, 1, 1, 1, 0, 1);
    cyc("R3", 1, 32'h308, 0, 1, 1, 0, 1);
    // R4 falling change tags next fetch
    cyc("R4", 0, 32'h0, 0, 0, 0, 0, 1);
    cyc("R4", 1, 32'h400, 0, 1, 0, 0, 1);
    // R5: several changes, one tagged fetch only
    cyc("R5", 0, 32'h0, 0, 0, 1, 0, 1);
    cyc("R5", 0, 32'h0, 0, 0, 0, 0, 1);
    cyc("R5", 1, 32'h500, 0, 1, 0, 0, 1);
    cyc("R5", 1, 32'h504, 0, 1, 0, 0, 1);
    // R6: show_all with level low
    cyc("R6", 1, 32'h600, 1, 1, 0, 1, 1);
    cyc("R6", 1, 32'h604, 0, 1, 0, 1, 1);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      cyc("R3", ($urandom % 4) != 0, $urandom, ($urandom % 3) == 0, ($urandom % 2) == 0,
          ($urandom % 16) == 0 ? !lvl : lvl, ($urandom % 8) == 0, ($urandom % 3) != 0);
    end
    finish_run();
  end
endmodule